// File: doc/BRIEF.md
# Block Sequence Number Stream Source

This block produces the framing of a sample stream on a fixed timing grid. Each block lasts a parameterised number of clock cycles. A start-of-block strobe marks the first cycle of each block and an end-of-block strobe marks the last. Every block carries a running sequence number. A periodic pulse input, for example one pulse per second, sets where sync marks fall: each pulse marks the first block that starts at or after it. The pulse period does not have to be a whole number of blocks.

Output can start in two ways. In the first, the block starts producing blocks at once. In the second, it waits for the next pulse, lets a loaded number of clock cycles pass, and then starts. Its first block carries a loaded sequence number. Software chooses both loaded values so that the sequence numbers line up with a common time origin. Three status outputs report the start:
- a level that shows the block is producing output,
- a one-cycle pulse on the first block after a start,
- a level that covers the first sync interval.

The stream output has no ready input. The grid runs freely, so no back-pressure is possible, and a consumer must accept every cycle in which `out_valid_o` is high. Internally the pulse is delayed by three cycles, so the output grid lags the pulse reference by a fixed three cycles.

Top module: `bsn_grid_source`

## Requirements
- R1: While valid stays high, `out_sop_o` and `out_eop_o` are high exactly BLOCK_LEN-1 cycles apart. The next block's sop follows in the cycle right after an eop, with no gap.
- R2: `out_bsn_o` holds its value during a block and steps up by one after each eop. It wraps from 2^BSN_W-1 to 0.
- R3: From idle, if `run_en_i` is high and `align_en_i` is low in cycle c, valid rises in cycle c+1 on a sop, and bsn equals `bsn_init_i`.
- R4: From idle, if both enables are high and the next pulse occurs in cycle t, the first valid sop comes in cycle t+3+`start_ofs_i`, and bsn equals `bsn_init_i`. Here "the next pulse" is the first pulse in cycle c-1 or later, where c is the cycle in which both enables were first seen high.
- R5: `out_sync_o` is high only in sop cycles. The first block after any start carries sync.
- R6: If the pulse is high in cycle t, sync appears on the first sop in cycle t+3 or later. When no sop falls in cycle t+3, the pulse is held pending until the next sop.
- R7: When `run_en_i` is low in an eop cycle, valid falls in the next cycle. Valid never falls anywhere except right after an eop.
- R8: `active_o` equals `out_valid_o` in every cycle.
- R9: `restart_o` is high only in the sop cycle of the first block after a start. Valid is low in the cycle before it.
- R10: `first_intv_o` rises together with `restart_o` and stays high until the next sync. It is low in that sync cycle and whenever valid is low.
- R11: If `run_en_i` drops while the block waits for a pulse or counts the offset, the start is abandoned and valid stays low.
- R12: During reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Periodic single-cycle timing pulse |
| run_en_i | input | 1 | Output enable; low stops output at the end of the current block |
| align_en_i | input | 1 | When high together with run_en_i, start waits for the next pulse |
| bsn_init_i | input | BSN_W | Sequence number of the first block after a start |
| start_ofs_i | input | OFS_W | Cycles between the delayed pulse and the first sop in an aligned start |
| out_valid_o | output | 1 | Stream valid |
| out_sop_o | output | 1 | First cycle of a block |
| out_eop_o | output | 1 | Last cycle of a block |
| out_sync_o | output | 1 | Sync mark on a sop |
| out_bsn_o | output | BSN_W | Block sequence number |
| active_o | output | 1 | High while output is produced |
| restart_o | output | 1 | Pulse on the first block after a start |
| first_intv_o | output | 1 | High through the first sync interval after a start |

## Verification
The pulse period (16) is not a multiple of the block length (5), so most pulses land mid-block. A design that put sync on the pulse cycle itself, or dropped the pending flag, would show syncs on non-sop cycles or lose them. Aligned starts are tried with zero offset and with the largest offset, which exposes off-by-one errors in the offset counter and in the three-cycle lag. A start value two below the wrap point checks that the sequence number rolls over to zero. Random enable drops in mid-block catch a design that cuts a frame short, and a start cancelled while waiting for the pulse catches a design that begins output anyway.

// File: rtl/bsrc_pkg.sv
`timescale 1ns/1ps
package bsrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_OFS  = 2'd2,
    ST_RUN  = 2'd3
  } bsrc_state_t;

  // cycles between the pulse input and the grid that reacts to it
  localparam int unsigned GRID_LAG = 3;
endpackage

// File: rtl/bsrc_pulse_dly.sv
`timescale 1ns/1ps
module bsrc_pulse_dly #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic arm_tap_o,
  output logic grid_tap_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[DEPTH-2:0], pulse_i};
  end

  // one stage early for the start controller, so the first sop can meet the grid tap
  assign arm_tap_o  = sr_q[DEPTH-2];
  assign grid_tap_o = sr_q[DEPTH-1];
endmodule

// File: rtl/bsrc_start_ctrl.sv
`timescale 1ns/1ps
module bsrc_start_ctrl
  import bsrc_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en_i,
  input  logic             align_en_i,
  input  logic             arm_tap_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             blk_end_i,
  output bsrc_state_t      state_o,
  output logic             load_o,
  output logic             first_o
);
  bsrc_state_t      state_q, state_n;
  logic [OFS_W-1:0] cnt_q, cnt_n;
  logic             first_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_en_i) begin
          if (align_en_i) state_n = ST_ARM;
          else begin
            state_n = ST_RUN;
            load_o  = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (!run_en_i) state_n = ST_IDLE;
        else if (arm_tap_i) begin
          if (ofs_i == '0) begin
            state_n = ST_RUN;
            load_o  = 1'b1;
          end else begin
            state_n = ST_OFS;
            cnt_n   = ofs_i;
          end
        end
      end
      ST_OFS: begin
        if (!run_en_i) state_n = ST_IDLE;
        else if (cnt_q == OFS_W'(1)) begin
          state_n = ST_RUN;
          load_o  = 1'b1;
        end else cnt_n = cnt_q - OFS_W'(1);
      end
      ST_RUN: begin
        if (blk_end_i && !run_en_i) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      first_q <= load_o;
    end
  end

  assign state_o = state_q;
  assign first_o = first_q;

  // offset countdown never sits at zero, otherwise the start would hang (R4)
  assert_ofs_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_OFS |-> cnt_q != '0);
  // the first-block flag only appears while running (R9)
  assert_first_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> state_q == ST_RUN);
endmodule

// File: rtl/bsrc_grid.sv
`timescale 1ns/1ps
module bsrc_grid #(
  parameter int BLOCK_LEN = 5,
  parameter int BSN_W     = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [BSN_W-1:0] init_i,
  output logic             sop_o,
  output logic             eop_o,
  output logic [BSN_W-1:0] bsn_o
);
  localparam int POS_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [BSN_W-1:0] bsn_q;

  assign sop_o = run_i && (pos_q == '0);
  assign eop_o = run_i && (pos_q == LAST);
  assign bsn_o = bsn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      bsn_q <= '0;
    end else if (load_i) begin
      pos_q <= '0;
      bsn_q <= init_i;
    end else if (run_i) begin
      pos_q <= eop_o ? '0 : pos_q + POS_W'(1);
      if (eop_o) bsn_q <= bsn_q + BSN_W'(1);
    end
  end

  // an eop is followed by a fresh sop or by idle (R1)
  assert_eop_then_sop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && eop_o |=> (!run_i || sop_o));
  // sequence number steps by one across each block boundary (R2)
  assert_bsn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && eop_o |=> bsn_o == $past(bsn_o) + BSN_W'(1));
  // no frame left open when output stops (R7)
  assert_no_midblock_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !eop_o |=> run_i);
endmodule

// File: rtl/bsrc_sync_gen.sv
`timescale 1ns/1ps
module bsrc_sync_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic track_i,
  input  logic sop_i,
  input  logic first_i,
  input  logic pulse_i,
  output logic sync_o,
  output logic restart_o,
  output logic first_intv_o
);
  logic pend_q;
  logic intv_q;

  assign sync_o       = sop_i && (pend_q || pulse_i || first_i);
  assign restart_o    = sop_i && first_i;
  assign first_intv_o = run_i && (restart_o || (intv_q && !sync_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      intv_q <= 1'b0;
    end else begin
      pend_q <= track_i ? ((pend_q || pulse_i) && !sop_i) : 1'b0;
      if (!run_i)         intv_q <= 1'b0;
      else if (restart_o) intv_q <= 1'b1;
      else if (sync_o)    intv_q <= 1'b0;
    end
  end

  assert_sync_on_sop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> sop_i);
  assert_restart_after_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> !$past(run_i));
  assert_intv_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_intv_o) |-> restart_o);
endmodule

// File: rtl/bsn_grid_source.sv
`timescale 1ns/1ps
module bsn_grid_source
  import bsrc_pkg::*;
#(
  parameter int BLOCK_LEN = 5,
  parameter int BSN_W     = 31,
  localparam int OFS_W    = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             run_en_i,
  input  logic             align_en_i,
  input  logic [BSN_W-1:0] bsn_init_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  output logic             out_valid_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  output logic             out_sync_o,
  output logic [BSN_W-1:0] out_bsn_o,
  output logic             active_o,
  output logic             restart_o,
  output logic             first_intv_o
);
  logic        arm_tap, grid_tap;
  bsrc_state_t state;
  logic        load, first, run, track;

  bsrc_pulse_dly #(.DEPTH(GRID_LAG)) u_dly (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
    .arm_tap_o(arm_tap), .grid_tap_o(grid_tap)
  );

  bsrc_start_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en_i(run_en_i), .align_en_i(align_en_i),
    .arm_tap_i(arm_tap), .ofs_i(start_ofs_i), .blk_end_i(out_eop_o),
    .state_o(state), .load_o(load), .first_o(first)
  );

  assign run   = (state == ST_RUN);
  assign track = (state == ST_RUN) || (state == ST_OFS);

  bsrc_grid #(.BLOCK_LEN(BLOCK_LEN), .BSN_W(BSN_W)) u_grid (
    .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load), .init_i(bsn_init_i),
    .sop_o(out_sop_o), .eop_o(out_eop_o), .bsn_o(out_bsn_o)
  );

  bsrc_sync_gen u_sync (
    .clk(clk), .rst_n(rst_n), .run_i(run), .track_i(track), .sop_i(out_sop_o),
    .first_i(first), .pulse_i(grid_tap), .sync_o(out_sync_o),
    .restart_o(restart_o), .first_intv_o(first_intv_o)
  );

  assign out_valid_o = run;
  assign active_o    = run;
endmodule

// File: tb/bsn_grid_source_test.sv
`timescale 1ns/1ps
module bsn_grid_source_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLOCK_LEN  = 5;
  localparam int BSN_W      = 31;
  localparam int OFS_W      = 3;
  localparam int PULSE_PER  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_i = 1'b0;
  logic run_en_i = 1'b0;
  logic align_en_i = 1'b0;
  logic [BSN_W-1:0] bsn_init_i = '0;
  logic [OFS_W-1:0] start_ofs_i = '0;
  logic out_valid_o, out_sop_o, out_eop_o, out_sync_o;
  logic [BSN_W-1:0] out_bsn_o;
  logic active_o, restart_o, first_intv_o;

  bsn_grid_source #(.BLOCK_LEN(BLOCK_LEN), .BSN_W(BSN_W)) uut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .run_en_i(run_en_i),
    .align_en_i(align_en_i), .bsn_init_i(bsn_init_i), .start_ofs_i(start_ofs_i),
    .out_valid_o(out_valid_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .out_sync_o(out_sync_o), .out_bsn_o(out_bsn_o), .active_o(active_o),
    .restart_o(restart_o), .first_intv_o(first_intv_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit pulse_on = 0;
  int unsigned pulse_phase = 0;
  bit mcheck = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk)
    pulse_i <= pulse_on && ((cyc % PULSE_PER) == pulse_phase);

  // reference model: modes 0 idle, 1 wait pulse, 2 offset count, 3 running
  int m_mode = 0, m_pos = 0, m_cnt = 0;
  logic [BSN_W-1:0] m_bsn = '0;
  bit m_pend = 0, m_first = 0, m_intv = 0;
  bit [2:0] m_ph = '0;

  function automatic bit e_valid(); return m_mode == 3; endfunction
  function automatic bit e_sop(); return (m_mode == 3) && (m_pos == 0); endfunction
  function automatic bit e_eop(); return (m_mode == 3) && (m_pos == BLOCK_LEN - 1); endfunction
  function automatic bit e_sync(); return e_sop() && (m_pend || m_ph[2] || m_first); endfunction
  function automatic bit e_restart(); return e_sop() && m_first; endfunction
  function automatic bit e_intv(); return e_valid() && (e_restart() || (m_intv && !e_sync())); endfunction

  always @(posedge clk) begin
    bit s, e, sy, rs, ld;
    int nm;
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_cnt = 0; m_bsn = '0;
      m_pend = 0; m_first = 0; m_intv = 0; m_ph = '0;
    end else begin
      s = e_sop(); e = e_eop(); sy = e_sync(); rs = e_restart();
      ld = 0; nm = m_mode;
      case (m_mode)
        0: if (run_en_i) begin
             if (align_en_i) nm = 1; else begin nm = 3; ld = 1; end
           end
        1: if (!run_en_i) nm = 0;
           else if (m_ph[1]) begin
             if (start_ofs_i == 0) begin nm = 3; ld = 1; end
             else begin nm = 2; m_cnt = int'(start_ofs_i); end
           end
        2: if (!run_en_i) nm = 0;
           else if (m_cnt == 1) begin nm = 3; ld = 1; end
           else m_cnt = m_cnt - 1;
        default: if (e && !run_en_i) nm = 0;
      endcase
      m_intv = (m_mode != 3) ? 1'b0 : rs ? 1'b1 : sy ? 1'b0 : m_intv;
      m_pend = (m_mode == 2 || m_mode == 3) ? ((m_pend || m_ph[2]) && !s) : 1'b0;
      if (ld) begin m_pos = 0; m_bsn = bsn_init_i; end
      else if (m_mode == 3) begin
        m_pos = e ? 0 : m_pos + 1;
        if (e) m_bsn = m_bsn + 1'b1;
      end
      m_first = ld;
      m_mode = nm;
      m_ph = {m_ph[1:0], pulse_i};
    end
  end

  // per-cycle comparison and directed monitors
  bit prev_valid = 0, prev_eop = 0;
  bit first_seen = 0, first_sync = 0, first_rst = 0;
  int unsigned first_cyc = 0;
  logic [BSN_W-1:0] first_bsn = '0;

  always @(negedge clk) begin
    if (mcheck) begin
      chk("R7", "valid", out_valid_o, e_valid());
      chk("R1", "sop", out_sop_o, e_sop());
      chk("R1", "eop", out_eop_o, e_eop());
      chk("R6", "sync", out_sync_o, e_sync());
      if (out_valid_o) chk("R2", "bsn", out_bsn_o, m_bsn);
      chk("R8", "active", active_o, out_valid_o);
      chk("R9", "restart", restart_o, e_restart());
      chk("R10", "first_intv", first_intv_o, e_intv());
      if (out_valid_o && !prev_valid && !first_seen) begin
        first_seen = 1; first_cyc = cyc; first_bsn = out_bsn_o;
        first_sync = out_sync_o; first_rst = restart_o;
      end
      if (!out_valid_o && prev_valid) chk("R7", "stop after eop", prev_eop, 1);
      prev_valid = out_valid_o;
      prev_eop = out_eop_o;
    end
  end

  task automatic go_idle();
    run_en_i = 0; align_en_i = 0;
    while (out_valid_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int unsigned c, ofs, seen;
    logic [BSN_W-1:0] init;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk("R12", "reset valid", out_valid_o, 0);
    chk("R12", "reset sop/eop/sync", {out_sop_o, out_eop_o, out_sync_o}, 0);
    chk("R12", "reset status", {active_o, restart_o, first_intv_o}, 0);
    chk("R12", "reset bsn", out_bsn_o, 0);
    rst_n = 1; mcheck = 1; pulse_on = 1;
    repeat (7) @(negedge clk);

    // immediate starts with random enable drops
    for (int k = 0; k < 4; k++) begin
      init = BSN_W'($urandom);
      bsn_init_i = init; run_en_i = 1; align_en_i = 0;
      c = cyc; first_seen = 0;
      repeat (2) @(negedge clk);
      chk("R3", "first valid cycle", first_cyc, c + 1);
      chk("R3", "first bsn", first_bsn, init);
      chk("R5", "first block sync", first_sync, 1);
      chk("R9", "restart on first block", first_rst, 1);
      for (int j = 0; j < 3; j++) begin
        repeat (10 + $urandom % 25) @(negedge clk);
        run_en_i = 0;
        repeat (1 + $urandom % 3) @(negedge clk);
        run_en_i = 1;
      end
      repeat (20 + $urandom % 30) @(negedge clk);
      go_idle();
    end

    // aligned starts, offsets 0 and max first, then random
    for (int k = 0; k < 8; k++) begin
      ofs = (k == 0) ? 0 : (k == 1) ? BLOCK_LEN - 1 : $urandom % BLOCK_LEN;
      pulse_phase = $urandom % PULSE_PER;
      init = BSN_W'($urandom);
      while ((cyc % PULSE_PER) != ((pulse_phase + 5) % PULSE_PER)) @(negedge clk);
      bsn_init_i = init; start_ofs_i = OFS_W'(ofs);
      run_en_i = 1; align_en_i = 1;
      c = cyc; first_seen = 0;
      repeat (15 + ofs) @(negedge clk);
      chk("R4", "aligned first valid cycle", first_cyc, c + 14 + ofs);
      chk("R4", "aligned first bsn", first_bsn, init);
      chk("R5", "aligned first sync", first_sync, 1);
      repeat (30 + $urandom % 60) @(negedge clk);
      go_idle();
    end

    // cancelled aligned start
    pulse_phase = 3;
    while ((cyc % PULSE_PER) != 8) @(negedge clk);
    run_en_i = 1; align_en_i = 1; start_ofs_i = 3'd2;
    repeat (5) @(negedge clk);
    run_en_i = 0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid_o) seen++;
    end
    chk("R11", "valid after cancel", seen, 0);
    align_en_i = 0;

    // sequence number wrap
    bsn_init_i = {BSN_W{1'b1}} - BSN_W'(1);
    run_en_i = 1;
    @(negedge clk);
    chk("R2", "bsn before wrap", out_bsn_o, {BSN_W{1'b1}} - BSN_W'(1));
    repeat (BLOCK_LEN) @(negedge clk);
    chk("R2", "bsn at max", out_bsn_o, {BSN_W{1'b1}});
    repeat (BLOCK_LEN) @(negedge clk);
    chk("R2", "bsn wrapped", out_bsn_o, 0);
    chk("R1", "sop at wrap", out_sop_o, 1);
    go_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule